// File: doc/BRIEF.md
# Ethernet PHY Management Frame Master

This block is the master side of the two-wire management bus used to reach Ethernet PHY registers. A host asks for one register access by pulsing a request strobe. With it come a read/write flag, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The block then produces the serial management clock and drives or releases the bidirectional data pin. The pad itself sits outside the block, which provides separate data-out, output-enable and data-in signals.

Every frame opens with a long run of ones. A header follows, then the turnaround and data fields. On a read, the block checks that the PHY pulls the line low at the turnaround. If the PHY does not, the block clocks out a recovery run with the line released, then ends the access with an error. The management clock is the system clock divided by `2*HALF_CYC`. Each access ends with a one-cycle completion pulse.

Top module: `mdio_master`

## Requirements
- R1: Every frame begins with 32 management clock periods in which the data pin is driven (oe=1) with the value 1.
- R2: After the preamble, the start bits 0,1 are driven, followed by the opcode: 1,0 for a read (rd_i=1) and 0,1 for a write (rd_i=0).
- R3: After the opcode, the 5-bit PHY address is driven, then the 5-bit register address, each most significant bit first.
- R4: On a write, the header is followed by the driven turnaround 1,0 and then the 16 write-data bits, most significant first.
- R5: A write frame ends with one more clock period in which the pin is released (oe=0), for 65 periods in all. The pin is released in the cycle in which done_o is high.
- R6: On a read, the pin is released from the turnaround period onward. If the line is low at the end of the turnaround period, the next 16 periods are sampled at the end of their high phase, most significant bit first. Two released idle periods follow (65 in all), and the sampled word then appears on rdata_o.
- R7: If the read turnaround sample is high, the block gives 32 more released periods (79 in all) and completes with err_o=1, leaving rdata_o unchanged. err_o stays high until the next request is accepted and is 0 after any successful access.
- R8: Each half of the management clock lasts HALF_CYC system clock cycles. When idle, mdc_o is held at 0 and mdio_oe_o at 0.
- R9: mdio_o and mdio_oe_o change only in cycles where mdc_o is low, and never at a rising edge of mdc_o.
- R10: done_o is high for exactly one system cycle per frame. A request raised while a frame is in progress is ignored and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request strobe, taken only when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Data of the last successful read |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Turnaround failure flag of the last access |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Data pin output value |
| mdio_oe_o | output | 1 | Data pin output enable |
| mdio_i | input | 1 | Data pin input value |

## Verification
The assertions check the cycle-level rules on every cycle: the half-period length of the management clock, data held stable over each rising edge, the quiet idle pin state, the single-cycle completion pulse, and the error flag rising only together with completion. Frame content can only be shown by the bench's scenarios. This covers the bit order of the header and data, the write turnaround, the read sampling point, the recovery run after a bad turnaround, the retained read data, and the rejection of requests while busy. In those scenarios a PHY model answers on the pin and a scoreboard compares each captured frame.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_LEN   = 32;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int HDR_LEN   = 4 + 2 * ADDR_W;
  localparam int WR_LEN    = HDR_LEN + 2 + DATA_W;
  localparam int RECOV_LEN = 32;
  localparam int RD_TAIL   = 2;
  localparam int WR_TAIL   = 1;
  localparam int CNT_W     = $clog2(WR_LEN + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRE, ST_SHIFT, ST_TA, ST_RDATA, ST_TAIL, ST_RECOV
  } mdio_st_e;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int HALF_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic slot_end_o
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          last;

  assign last = (cnt_q == CW'(HALF_CYC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (last) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign mdc_o      = mdc_q;
  // end of high phase: data sampled and next bit launched here
  assign slot_end_o = run_i & last & mdc_q;
endmodule

// File: rtl/mdio_rx_capture.sv
module mdio_rx_capture #(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  input  logic              load_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      rdata_o <= '0;
    end else begin
      if (shift_i) sh_q <= {sh_q[DATA_W-2:0], bit_i};
      if (load_i)  rdata_o <= sh_q;
    end
  end
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              slot_end_i,
  input  logic              mdio_i,
  output logic              run_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              cap_o,
  output logic              load_o,
  output logic              done_o,
  output logic              err_o
);
  mdio_st_e           st_q;
  logic               is_rd_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [WR_LEN-1:0]  tx_q;
  logic [CNT_W-1:0]   shift_last;
  logic [CNT_W-1:0]   tail_last;

  assign shift_last = is_rd_q ? CNT_W'(HDR_LEN - 1) : CNT_W'(WR_LEN - 1);
  assign tail_last  = is_rd_q ? CNT_W'(RD_TAIL - 1) : CNT_W'(WR_TAIL - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      is_rd_q <= 1'b0;
      cnt_q   <= '0;
      tx_q    <= '0;
      done_o  <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (req_i) begin
          st_q    <= ST_PRE;
          is_rd_q <= rd_i;
          cnt_q   <= '0;
          err_o   <= 1'b0;
          tx_q    <= rd_i ? {2'b01, 2'b10, phy_addr_i, reg_addr_i, {(WR_LEN-HDR_LEN){1'b0}}}
                          : {2'b01, 2'b01, phy_addr_i, reg_addr_i, 2'b10, wdata_i};
        end
      end else if (slot_end_i) begin
        cnt_q <= cnt_q + 1'b1;
        unique case (st_q)
          ST_PRE:
            if (cnt_q == CNT_W'(PRE_LEN - 1)) begin
              st_q  <= ST_SHIFT;
              cnt_q <= '0;
            end
          ST_SHIFT: begin
            tx_q <= {tx_q[WR_LEN-2:0], 1'b0};
            if (cnt_q == shift_last) begin
              st_q  <= is_rd_q ? ST_TA : ST_TAIL;
              cnt_q <= '0;
            end
          end
          ST_TA: begin
            st_q  <= mdio_i ? ST_RECOV : ST_RDATA;
            cnt_q <= '0;
          end
          ST_RDATA:
            if (cnt_q == CNT_W'(DATA_W - 1)) begin
              st_q  <= ST_TAIL;
              cnt_q <= '0;
            end
          ST_TAIL:
            if (cnt_q == tail_last) begin
              st_q   <= ST_IDLE;
              done_o <= 1'b1;
            end
          ST_RECOV:
            if (cnt_q == CNT_W'(RECOV_LEN - 1)) begin
              st_q   <= ST_IDLE;
              done_o <= 1'b1;
              err_o  <= 1'b1;
            end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign run_o     = (st_q != ST_IDLE);
  assign mdio_oe_o = (st_q == ST_PRE) || (st_q == ST_SHIFT);
  assign mdio_o    = (st_q == ST_PRE) || ((st_q == ST_SHIFT) && tx_q[WR_LEN-1]);
  assign cap_o     = slot_end_i && (st_q == ST_RDATA);
  assign load_o    = slot_end_i && (st_q == ST_TAIL) && is_rd_q && (cnt_q == tail_last);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int HALF_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] phy_addr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              done_o,
  output logic              err_o,
  output logic              mdc_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  input  logic              mdio_i
);
  logic busy;
  logic slot_end;
  logic cap;
  logic load;

  mdio_clk_gen #(.HALF_CYC(HALF_CYC)) u_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(busy),
    .mdc_o(mdc_o), .slot_end_o(slot_end)
  );

  mdio_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .rd_i(rd_i),
    .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
    .slot_end_i(slot_end), .mdio_i(mdio_i), .run_o(busy),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o), .cap_o(cap), .load_o(load),
    .done_o(done_o), .err_o(err_o)
  );

  mdio_rx_capture #(.DATA_W(DATA_W)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .shift_i(cap), .bit_i(mdio_i),
    .load_i(load), .rdata_o(rdata_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int HALF_CYC = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic mdc_i,
  input logic dat_i,
  input logic oe_i,
  input logic done_i,
  input logic err_i,
  input logic busy_i
);
  logic        mdc_q;
  logic [15:0] hc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mdc_q <= 1'b0;
      hc_q  <= '0;
    end else begin
      mdc_q <= mdc_i;
      if (mdc_i != mdc_q)  hc_q <= '0;
      else if (~&hc_q)     hc_q <= hc_q + 1'b1;
    end
  end

  p_high_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdc_q && !mdc_i) |-> (hc_q == 16'(HALF_CYC - 1)));

  p_idle_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> (!mdc_i && !oe_i));

  p_stable_rise_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mdc_i) |-> ($stable(dat_i) && $stable(oe_i)));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_err_at_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_i) |-> done_i);

  p_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> !oe_i);
endmodule

bind mdio_master mdio_master_chk #(.HALF_CYC(HALF_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mdc_i(mdc_o), .dat_i(mdio_o),
  .oe_i(mdio_oe_o), .done_i(done_o), .err_i(err_o), .busy_i(busy)
);

// File: tb/mdio_master_bench.sv
module mdio_master_bench;
  localparam int HALF_CYC = 4;
  localparam int MAXB = 80;

  typedef struct packed {
    logic [6:0]      n;
    logic [MAXB-1:0] oe;
    logic [MAXB-1:0] d;
    logic [15:0]     rdata;
    logic            err;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, rd = 1'b0;
  logic [4:0]  phy = '0, rega = '0;
  logic [15:0] wd = '0;
  logic [15:0] rdata;
  logic        done, err, mdc, mdo, moe;
  logic        mdi = 1'b1;

  int checks = 0, fails = 0;
  exp_t sb[$];
  logic        phy_ta_bad = 1'b0;
  logic [15:0] phy_data = '0;
  logic [15:0] last_rdata = '0;

  always #2 clk = ~clk;

  mdio_master #(.HALF_CYC(HALF_CYC)) u_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .rd_i(rd),
    .phy_addr_i(phy), .reg_addr_i(rega), .wdata_i(wd), .rdata_o(rdata),
    .done_o(done), .err_o(err), .mdc_o(mdc), .mdio_o(mdo),
    .mdio_oe_o(moe), .mdio_i(mdi)
  );

  task automatic chk(input bit ok, input string tag, input logic [MAXB-1:0] act,
                     input logic [MAXB-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic phy_bit(input int idx);
    if (idx == 46) return phy_ta_bad;
    if (idx >= 47 && idx <= 62) return phy_data[15 - (idx - 47)];
    return 1'b1;
  endfunction

  // monitor: captures frame bits at mdc rise, plays PHY, pops scoreboard on done
  initial begin
    int idx = 0;
    int hi_len = 0;
    bit half_bad = 0;
    bit done_pend = 0;
    logic mdc_p = 1'b0;
    logic [MAXB-1:0] c_oe = '0, c_d = '0;
    forever begin
      @(negedge clk);
      if (done_pend) begin
        chk(!done, "R10 done single cycle", MAXB'(done), '0);
        done_pend = 0;
      end
      if (mdc && !mdc_p) begin
        if (idx < MAXB) begin c_oe[idx] = moe; c_d[idx] = mdo; end
        idx++;
        hi_len = 1;
      end else if (mdc) begin
        hi_len++;
      end
      if (!mdc && mdc_p) begin
        if (hi_len != HALF_CYC) half_bad = 1;
        mdi = phy_bit(idx);
      end
      mdc_p = mdc;
      if (done) begin
        exp_t e;
        done_pend = 1;
        if (sb.size() == 0) begin
          chk(0, "R10 unexpected frame", '0, '0);
        end else begin
          logic [MAXB-1:0] m;
          e = sb.pop_front();
          m = e.oe;
          chk(idx == int'(e.n), "R5/R6/R7 period count", MAXB'(idx), MAXB'(e.n));
          chk(c_oe[31:0] == '1 && c_d[31:0] == '1, "R1 preamble",
              MAXB'({c_oe[31:0], c_d[31:0]}), '1);
          chk(c_d[35:32] == e.d[35:32], "R2 start/opcode",
              MAXB'(c_d[35:32]), MAXB'(e.d[35:32]));
          chk(c_d[45:36] == e.d[45:36], "R3 addresses",
              MAXB'(c_d[45:36]), MAXB'(e.d[45:36]));
          chk(c_oe == e.oe, "R4/R5/R6/R7 output enable", c_oe, e.oe);
          chk((c_d & m) == (e.d & m), "R4 driven bits", c_d & m, e.d & m);
          chk(rdata == e.rdata, "R6/R7 rdata", MAXB'(rdata), MAXB'(e.rdata));
          chk(err == e.err, "R7 err flag", MAXB'(err), MAXB'(e.err));
          chk(!half_bad, "R8 half period", MAXB'(half_bad), '0);
        end
        idx = 0; half_bad = 0; c_oe = '0; c_d = '0;
        mdi = 1'b1;
      end
    end
  end

  task automatic run_txn(input bit r, input logic [4:0] pa, input logic [4:0] ra,
                         input logic [15:0] w, input bit ta_bad, input logic [15:0] pd,
                         input bit poke);
    exp_t e;
    e = '0;
    for (int i = 0; i < 32; i++) begin e.oe[i] = 1; e.d[i] = 1; end
    e.oe[35:32] = '1;
    e.d[32] = 0; e.d[33] = 1;
    e.d[34] = r; e.d[35] = !r;
    for (int i = 0; i < 5; i++) begin
      e.oe[36+i] = 1; e.d[36+i] = pa[4-i];
      e.oe[41+i] = 1; e.d[41+i] = ra[4-i];
    end
    if (!r) begin
      e.oe[47:46] = 2'b11; e.d[46] = 1; e.d[47] = 0;
      for (int i = 0; i < 16; i++) begin e.oe[48+i] = 1; e.d[48+i] = w[15-i]; end
      e.n = 65; e.err = 0; e.rdata = last_rdata;
    end else if (ta_bad) begin
      e.n = 79; e.err = 1; e.rdata = last_rdata;
    end else begin
      e.n = 65; e.err = 0; e.rdata = pd; last_rdata = pd;
    end
    sb.push_back(e);
    phy_ta_bad = ta_bad; phy_data = pd;
    @(negedge clk);
    rd = r; phy = pa; rega = ra; wd = w; req = 1;
    @(negedge clk);
    req = 0;
    if (poke) begin
      repeat (60) @(negedge clk);
      rd = !r; phy = ~pa; req = 1;
      @(negedge clk);
      req = 0;
    end
    while (sb.size() != 0) @(negedge clk);
    begin
      bit quiet = 1;
      repeat (4 * HALF_CYC + 4) begin
        @(negedge clk);
        if (mdc || moe) quiet = 0;
      end
      chk(quiet, "R8/R10 idle after frame", MAXB'({mdc, moe}), '0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!mdc && !moe && !done && !err && rdata == '0, "R8 reset state",
        MAXB'({mdc, moe, done, err, rdata}), '0);
    run_txn(0, 5'h01, 5'h00, 16'hA5C3, 0, 16'h0000, 0);  // R4
    run_txn(0, 5'h1F, 5'h1F, 16'hFFFF, 0, 16'h0000, 0);  // R3 all ones
    run_txn(0, 5'h00, 5'h00, 16'h0000, 0, 16'h0000, 1);  // R10 busy request
    run_txn(1, 5'h12, 5'h03, 16'h0000, 0, 16'hBEEF, 0);  // R6
    run_txn(1, 5'h0A, 5'h15, 16'h0000, 0, 16'h0001, 0);  // R6 lsb only
    run_txn(1, 5'h07, 5'h1E, 16'h0000, 1, 16'h5555, 0);  // R7 bad turnaround
    run_txn(1, 5'h10, 5'h01, 16'h0000, 0, 16'h8000, 1);  // R7 err cleared, R10
    run_txn(0, 5'h03, 5'h11, 16'h1234, 0, 16'h0000, 1);  // R9 via assertions
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule